// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects five interrupt sources and turns them into one request line and a 16-bit vector address for a small CPU core. The sources are two active-low external pins, two timer overflow pulses and one serial event, which is the OR of a receive flag and a transmit flag that the serial block holds. Software programs three 8-bit registers through a simple write port: an enable register, a priority register and a trigger-type register for the two pins.

Two priority levels are supported. The controller records which levels currently have a handler running, so a high-priority source can break into a low-priority handler, while anything at or below a running handler's level waits for its return. The CPU takes a request by pulsing an acknowledge, which also clears the latched flag of the source it took, and it ends a handler with a return pulse.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After synchronous reset the enable, priority and type registers are zero, no level is in service, `irq_o` is 0 and `vector_o` is 0000h.
- R2: A source can raise `irq_o` only while bit 7 (global enable) of the enable register is 1 and its own enable bit is 1; enable bits 0..4 belong to external 0, timer 0, external 1, timer 1 and serial.
- R3: The vector is 0003h for external 0, 000Bh for timer 0, 0013h for external 1, 001Bh for timer 1 and 0023h for serial; `vector_o` is 0000h while `irq_o` is 0.
- R4: Among pending sources of one level, the winner is the first in the order external 0, timer 0, external 1, timer 1, serial.
- R5: Priority register bits 0..4 (same source order) select high (1) or low (0); a pending high source wins over any low source.
- R6: While a low handler is in service, low requests are held and a high request still raises `irq_o` (preemption).
- R7: While a high handler is in service, `irq_o` stays 0 for every source.
- R8: A return pulse ends the high level if it is in service, otherwise the low level, and held requests of that level are then presented again.
- R9: Type register bit 0 (external 0) or bit 1 (external 1) set to 1 makes that pin edge-triggered: a high-to-low change across two successive samples latches a flag that stays after the pin returns high and is cleared when its vector is acknowledged; with the bit at 0 the request follows the low pin and an acknowledge does not clear it.
- R10: A one-cycle timer overflow pulse latches a request that holds until its vector is acknowledged.
- R11: The serial request is the OR of the receive and transmit flag inputs, and an acknowledge does not clear it.
- R12: The write select chooses enable (0), priority (1) or type (2); select 3 changes nothing.
- R13: An acknowledge while `irq_o` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n_i | input | 2 | External interrupt pins, active low (bit 0 is external 0) |
| tmr_ovf_i | input | 2 | Timer overflow pulses (bit 0 is timer 0) |
| ser_rx_flag_i | input | 1 | Serial receive flag |
| ser_tx_flag_i | input | 1 | Serial transmit flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 enable, 1 priority, 2 type |
| wr_data_i | input | 8 | Register write data |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| reti_i | input | 1 | Return-from-handler pulse |
| irq_o | output | 1 | Interrupt request to the CPU |
| vector_o | output | 16 | Vector address of the winning source |

## Verification
The embedded properties watch, on every cycle, that a request never appears without the global enable or while a high handler runs, that any presented vector is one of the five legal addresses, that an acknowledge at high level marks that level busy, that a return retires the high level before the low one, that a falling edge in edge mode always latches and a taken timer flag clears, and that a stray acknowledge leaves the service state untouched. Only the bench scenarios can show the exact arbitration order inside a level, the cross-level winner, the full preemption and return sequence, the difference between level and edge pins after acknowledge, the serial flags surviving an acknowledge and the ignored register select.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_EXT    = 2;
    localparam int NUM_TMR    = 2;
    localparam int NUM_SRC    = NUM_EXT + NUM_TMR + 1;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam int REG_W      = 8;
    localparam int GEN_BIT    = REG_W - 1;
    localparam int VEC_W      = 16;
    localparam int VEC_BASE   = 3;
    localparam int VEC_STRIDE = 8;
    localparam int SER_IDX    = NUM_SRC - 1;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PRIO   = 2'd1,
        SEL_TYPE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             valid;
        logic             high;
        logic [IDX_W-1:0] idx;
    } grant_t;

    function automatic logic [VEC_W-1:0] vector_of(input logic [IDX_W-1:0] idx);
        return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
    endfunction
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic req_o
);
    logic smp_now, smp_prev, flag_q;
    logic fall;

    assign fall = smp_prev & ~smp_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_now  <= 1'b1;
            smp_prev <= 1'b1;
            flag_q   <= 1'b0;
        end else begin
            smp_now  <= pin_n_i;
            smp_prev <= smp_now;
            if (edge_mode_i && fall)
                flag_q <= 1'b1;
            else if (clr_i || !edge_mode_i)
                flag_q <= 1'b0;
        end
    end

    assign req_o = edge_mode_i ? flag_q : ~smp_now;

    assert_edge_latch_R9: assert property (@(posedge clk) disable iff (rst)
        (edge_mode_i && smp_prev && !smp_now) |=> flag_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] prio_i,
    input  logic               allow_hi_i,
    input  logic               allow_lo_i,
    output grant_t             grant_o
);
    always_comb begin
        grant_o = '0;
        // low level first, descending so the lowest index is assigned last
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && !prio_i[i] && allow_lo_i) begin
                grant_o.valid = 1'b1;
                grant_o.high  = 1'b0;
                grant_o.idx   = IDX_W'(i);
            end
        end
        // high level overrides any low winner
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && prio_i[i] && allow_hi_i) begin
                grant_o.valid = 1'b1;
                grant_o.high  = 1'b1;
                grant_o.idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker (
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    input  logic take_high_i,
    input  logic ret_i,
    output logic in_hi_o,
    output logic in_lo_o
);
    logic hi_n, lo_n;

    always_comb begin
        hi_n = in_hi_o;
        lo_n = in_lo_o;
        if (ret_i) begin
            if (in_hi_o) hi_n = 1'b0;
            else         lo_n = 1'b0;
        end
        if (take_i) begin
            if (take_high_i) hi_n = 1'b1;
            else             lo_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_hi_o <= 1'b0;
            in_lo_o <= 1'b0;
        end else begin
            in_hi_o <= hi_n;
            in_lo_o <= lo_n;
        end
    end

    assert_take_high_R6: assert property (@(posedge clk) disable iff (rst)
        (take_i && take_high_i) |=> in_hi_o);

    assert_ret_order_R8: assert property (@(posedge clk) disable iff (rst)
        (ret_i && in_hi_o && !take_i) |=> (!in_hi_o && $stable(in_lo_o)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] ext_n_i,
    input  logic [NUM_TMR-1:0] tmr_ovf_i,
    input  logic               ser_rx_flag_i,
    input  logic               ser_tx_flag_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vector_o
);
    logic [REG_W-1:0]   en_q, prio_q;
    logic [NUM_EXT-1:0] type_q;
    logic [NUM_SRC-1:0] raw_req, pend, clr_vec;
    logic [NUM_TMR-1:0] tmr_flag;
    logic               in_hi, in_lo, take;
    grant_t             grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            prio_q <= '0;
            type_q <= '0;
        end else if (wr_en_i) begin
            case (reg_sel_e'(wr_sel_i))
                SEL_ENABLE: en_q   <= wr_data_i;
                SEL_PRIO:   prio_q <= wr_data_i;
                SEL_TYPE:   type_q <= wr_data_i[NUM_EXT-1:0];
                default:    ;
            endcase
        end
    end

    assign take = ack_i & grant.valid;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
        assign clr_vec[s] = take && (grant.idx == IDX_W'(s));
    end

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        irq_pin_cond u_pin (
            .clk         (clk),
            .rst         (rst),
            .pin_n_i     (ext_n_i[k]),
            .edge_mode_i (type_q[k]),
            .clr_i       (clr_vec[2*k]),
            .req_o       (raw_req[2*k])
        );
    end

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (rst)                  tmr_flag[k] <= 1'b0;
            else if (tmr_ovf_i[k])    tmr_flag[k] <= 1'b1;
            else if (clr_vec[2*k+1])  tmr_flag[k] <= 1'b0;
        end
        assign raw_req[2*k+1] = tmr_flag[k];

        assert_tmr_clear_R10: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[2*k+1] && !tmr_ovf_i[k]) |=> !tmr_flag[k]);
    end

    assign raw_req[SER_IDX] = ser_rx_flag_i | ser_tx_flag_i;
    assign pend = raw_req & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[GEN_BIT]}};

    irq_arbiter u_arb (
        .pend_i     (pend),
        .prio_i     (prio_q[NUM_SRC-1:0]),
        .allow_hi_i (~in_hi),
        .allow_lo_i (~in_hi & ~in_lo),
        .grant_o    (grant)
    );

    irq_level_tracker u_lvl (
        .clk         (clk),
        .rst         (rst),
        .take_i      (take),
        .take_high_i (grant.high),
        .ret_i       (reti_i),
        .in_hi_o     (in_hi),
        .in_lo_o     (in_lo)
    );

    assign irq_o    = grant.valid;
    assign vector_o = grant.valid ? vector_of(grant.idx) : '0;

    assert_global_gate_R2: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> en_q[GEN_BIT]);

    assert_high_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        in_hi |-> !irq_o);

    assert_vector_legal_R3: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (vector_o[2:0] == 3'b011 && vector_o <= VEC_W'(VEC_BASE + VEC_STRIDE*SER_IDX)));

    assert_stray_ack_R13: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_o && !reti_i) |=> ($stable(in_hi) && $stable(in_lo)));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC = 11;
    // {enable, priority, pins_n[1:0], {tx,rx}, exp_irq, exp_vector}
    localparam logic [36:0] TABLE [N_VEC] = '{
        {8'h00, 8'h00, 2'b00, 2'b01, 1'b0, 16'h0000},
        {8'h1F, 8'h00, 2'b00, 2'b01, 1'b0, 16'h0000},
        {8'h9F, 8'h00, 2'b00, 2'b01, 1'b1, 16'h0003},
        {8'h9E, 8'h00, 2'b00, 2'b01, 1'b1, 16'h0013},
        {8'h9A, 8'h00, 2'b00, 2'b01, 1'b1, 16'h0023},
        {8'h9F, 8'h10, 2'b00, 2'b01, 1'b1, 16'h0023},
        {8'h9F, 8'h04, 2'b00, 2'b01, 1'b1, 16'h0013},
        {8'h9F, 8'h00, 2'b01, 2'b01, 1'b1, 16'h0013},
        {8'h9F, 8'h00, 2'b11, 2'b10, 1'b1, 16'h0023},
        {8'h9F, 8'h00, 2'b11, 2'b00, 1'b0, 16'h0000},
        {8'h80, 8'h00, 2'b00, 2'b11, 1'b0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  ext_n;
    logic [1:0]  tmr_ovf;
    logic        rx, tx, wr_en, ack, reti;
    logic [1:0]  wr_sel;
    logic [7:0]  wr_data;
    logic        irq;
    logic [15:0] vector;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst(rst), .ext_n_i(ext_n), .tmr_ovf_i(tmr_ovf),
        .ser_rx_flag_i(rx), .ser_tx_flag_i(tx), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vector_o(vector)
    );

    task automatic check(input string req, input logic e_irq, input logic [15:0] e_vec);
        n_chk++;
        if (irq !== e_irq || vector !== e_vec) begin
            n_bad++;
            $display("FAIL %s: irq=%0b vector=%04h expected irq=%0b vector=%04h",
                     req, irq, vector, e_irq, e_vec);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    task automatic tmr_pulse(input int k);
        @(negedge clk); tmr_ovf[k] = 1'b1;
        @(negedge clk); tmr_ovf = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        ext_n = 2'b11; tmr_ovf = '0; rx = 0; tx = 0; wr_en = 0;
        wr_sel = '0; wr_data = '0; ack = 0; reti = 0;
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        do_reset();
        // R1: reset state, pins active but all registers zero
        ext_n = 2'b00; rx = 1'b1;
        idle(2);
        check("R1 reset state", 1'b0, 16'h0000);

        // R2 R3 R4 R5 R11: table of level-mode arbitration cases
        for (int t = 0; t < N_VEC; t++) begin
            wr(2'd0, TABLE[t][36:29]);
            wr(2'd1, TABLE[t][28:21]);
            ext_n = TABLE[t][20:19];
            {tx, rx} = TABLE[t][18:17];
            idle(2);
            check($sformatf("R2/R3/R4/R5/R11 table row %0d", t), TABLE[t][16], TABLE[t][15:0]);
        end

        // R12: select 3 ignored
        do_reset();
        wr(2'd0, 8'h81);
        ext_n = 2'b10;
        idle(2);
        check("R12 setup", 1'b1, 16'h0003);
        wr(2'd3, 8'h00);
        idle(1);
        check("R12 select 3 ignored", 1'b1, 16'h0003);

        // R9 level pin survives ack; R8 return presents it again
        do_ack();
        check("R6 low held while low in service", 1'b0, 16'h0000);
        do_reti();
        check("R9 level request not cleared by ack", 1'b1, 16'h0003);

        // R9 edge mode on external 1
        do_reset();
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h84);
        @(negedge clk); ext_n = 2'b01;
        @(negedge clk);
        check("R9 edge not yet latched", 1'b0, 16'h0000);
        @(negedge clk);
        check("R9 edge latched", 1'b1, 16'h0013);
        ext_n = 2'b11;
        idle(3);
        check("R9 flag held after pin high", 1'b1, 16'h0013);
        do_ack();
        do_reti();
        check("R9 flag cleared by ack", 1'b0, 16'h0000);

        // R10 timers
        do_reset();
        wr(2'd0, 8'h82);
        tmr_pulse(0);
        check("R10 timer 0 latched", 1'b1, 16'h000B);
        idle(3);
        check("R10 timer 0 held", 1'b1, 16'h000B);
        do_ack();
        do_reti();
        check("R10 timer 0 cleared by ack", 1'b0, 16'h0000);
        wr(2'd0, 8'h88);
        tmr_pulse(1);
        check("R3 timer 1 vector", 1'b1, 16'h001B);

        // R6 R7 R8 preemption sequence
        do_reset();
        wr(2'd0, 8'h83);
        wr(2'd1, 8'h02);
        ext_n = 2'b10;
        idle(2);
        check("R5 low ext0 alone", 1'b1, 16'h0003);
        do_ack();
        check("R6 low request held", 1'b0, 16'h0000);
        tmr_pulse(0);
        check("R6 high preempts low handler", 1'b1, 16'h000B);
        do_ack();
        check("R7 nothing while high in service", 1'b0, 16'h0000);
        tmr_pulse(0);
        check("R7 high request held", 1'b0, 16'h0000);
        do_reti();
        check("R8 high return releases high", 1'b1, 16'h000B);
        do_ack();
        do_reti();
        check("R8 low still in service", 1'b0, 16'h0000);
        do_reti();
        check("R8 low return releases low", 1'b1, 16'h0003);

        // R13 stray ack
        do_reset();
        wr(2'd0, 8'h81);
        do_ack();
        ext_n = 2'b10;
        idle(2);
        check("R13 stray ack ignored", 1'b1, 16'h0003);

        // R11 serial survives ack
        do_reset();
        wr(2'd0, 8'h90);
        rx = 1'b1;
        idle(1);
        check("R11 serial request", 1'b1, 16'h0023);
        do_ack();
        do_reti();
        check("R11 serial not cleared by ack", 1'b1, 16'h0023);

        finish_run();
    end
endmodule